// File: doc/BRIEF.md
# Power-Up Soft-Ramp Sequencer

This controller governs how an audio output comes up after reset. It keeps the output clamped to ground, with the audio core powered down, until the clock detector reports a lock. It then raises an output level code one step at a time, from zero to the mid-scale common-mode value. Audio playback is released only once that level is reached.

If the lock is lost while audio is playing, playback is cut at once. The level is then walked back down to zero and the clamp is applied again. The lock input is assumed to be synchronous to the system clock. The ramp speed is set by a divider parameter, and the code width by a width parameter.

Top module: `pwrup_ramp_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, the state code is 0 (POWERDOWN), clamp and power-down are 1, the level code is 0 and audio-enable is 0.
- R2: In POWERDOWN with lock low, the sequencer stays in POWERDOWN with clamp high and level 0.
- R3: In POWERDOWN with lock high at a clock edge, the state code becomes 1 (RAMP_UP) at that edge.
- R4: In RAMP_UP (code 1) and RAMP_DOWN (code 3), the level changes by exactly one every STEP_DIV clocks. The first change comes STEP_DIV edges after the ramp state was entered. The level never exceeds mid-scale 2^(CODE_W-1) and never leaves its range.
- R5: The edge on which RAMP_UP raises the level to mid-scale also sets the state code to 2 (NORMAL). Audio-enable is 1 exactly in NORMAL, where the level is held at mid-scale.
- R6: In NORMAL with lock low at an edge, audio-enable drops and the state code becomes 3 at that same edge. The level then steps down to 0, and the edge that makes it 0 returns the state to POWERDOWN.
- R7: In RAMP_UP with lock low at an edge, the state becomes RAMP_DOWN at that edge. The descent starts from the current level, with the step timer restarted.
- R8: Lock rising during RAMP_DOWN has no effect: the descent completes to POWERDOWN.
- R9: Clamp and power-down are 1 exactly in POWERDOWN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_lock_i | input | 1 | Clock detector reports valid clocks (synchronous) |
| clamp_o | output | 1 | Clamp output to ground |
| pdown_o | output | 1 | Audio core powered down |
| audio_en_o | output | 1 | Release the normal audio path |
| level_o | output | CODE_W | Output level code, mid-scale is common mode |
| seq_state_o | output | 2 | State code: 0 POWERDOWN, 1 RAMP_UP, 2 NORMAL, 3 RAMP_DOWN |

## Verification
The bench builds the block with CODE_W=6 and STEP_DIV=3, so mid-scale is 32 and a full ramp takes 96 clocks. Several complete rises and falls, plus lock drops and re-locks mid-ramp, fit in a few thousand cycles. A divider above one keeps the first-step delay and the timer restart on a direction change visible.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_PDOWN = 2'd0,
    SEQ_RISE  = 2'd1,
    SEQ_RUN   = 2'd2,
    SEQ_FALL  = 2'd3
  } seq_state_e;

  function automatic logic is_ramping(input seq_state_e s);
    return (s == SEQ_RISE) || (s == SEQ_FALL);
  endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int STEP_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (wrap)              cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (STEP_DIV > 1) begin : g_gap
      assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/ramp_level.sv
module ramp_level #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [CODE_W-1:0] level_o,
  output logic              near_top_o,
  output logic              near_bottom_o,
  output logic              empty_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

  function automatic logic [CODE_W-1:0] next_level(
    input logic [CODE_W-1:0] cur, input logic up, input logic dn);
    if (up && cur < MID)        return cur + 1'b1;
    else if (dn && cur != '0)   return cur - 1'b1;
    else                        return cur;
  endfunction

  logic [CODE_W-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= next_level(level_q, up_i, dn_i);
  end

  assign level_o       = level_q;
  assign near_top_o    = (level_q == MID - 1'b1);
  assign near_bottom_o = (level_q == CODE_W'(1));
  assign empty_o       = (level_q == '0);

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= MID);
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> (level_q == $past(level_q) + 1'b1) ||
                          (level_q == $past(level_q) - 1'b1));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwrup_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_i,
  input  logic       tick_i,
  input  logic       near_top_i,
  input  logic       near_bottom_i,
  input  logic       empty_i,
  output seq_state_e state_o,
  output logic       ramping_o,
  output logic       restart_o,
  output logic       up_o,
  output logic       dn_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_PDOWN: if (lock_i) state_d = SEQ_RISE;
      SEQ_RISE: begin
        if (!lock_i)                      state_d = SEQ_FALL;
        else if (tick_i && near_top_i)    state_d = SEQ_RUN;
      end
      SEQ_RUN:   if (!lock_i) state_d = SEQ_FALL;
      SEQ_FALL:  if (empty_i || (tick_i && near_bottom_i)) state_d = SEQ_PDOWN;
      default:   state_d = SEQ_PDOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_PDOWN;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign ramping_o = is_ramping(state_q);
  assign restart_o = (state_d != state_q);
  assign up_o      = (state_q == SEQ_RISE) && tick_i;
  assign dn_o      = (state_q == SEQ_FALL) && tick_i && !empty_i;

  assert_hold_pdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_PDOWN && !lock_i) |=> state_q == SEQ_PDOWN);
  assert_leave_pdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_PDOWN && lock_i) |=> state_q == SEQ_RISE);
  assert_drop_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && !lock_i) |=> state_q == SEQ_FALL);
  assert_abort_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RISE && !lock_i) |=> state_q == SEQ_FALL);
  assert_fall_completes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_FALL && !empty_i && !(tick_i && near_bottom_i)) |=> state_q == SEQ_FALL);

endmodule

// File: rtl/pwrup_ramp_seq.sv
module pwrup_ramp_seq
  import pwrup_seq_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int STEP_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_lock_i,
  output logic              clamp_o,
  output logic              pdown_o,
  output logic              audio_en_o,
  output logic [CODE_W-1:0] level_o,
  output logic [1:0]        seq_state_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

  seq_state_e state;
  logic ramping, restart, tick, step_up, step_dn;
  logic near_top, near_bottom, empty;

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .lock_i(clk_lock_i), .tick_i(tick),
    .near_top_i(near_top), .near_bottom_i(near_bottom), .empty_i(empty),
    .state_o(state), .ramping_o(ramping), .restart_o(restart),
    .up_o(step_up), .dn_o(step_dn)
  );

  step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(ramping), .restart_i(restart), .tick_o(tick)
  );

  ramp_level #(.CODE_W(CODE_W)) u_level (
    .clk(clk), .rst_n(rst_n), .up_i(step_up), .dn_i(step_dn), .level_o(level_o),
    .near_top_o(near_top), .near_bottom_o(near_bottom), .empty_o(empty)
  );

  assign clamp_o     = (state == SEQ_PDOWN);
  assign pdown_o     = (state == SEQ_PDOWN);
  assign audio_en_o  = (state == SEQ_RUN);
  assign seq_state_o = state;

  assert_clamp_at_ground_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |-> level_o == '0);
  assert_audio_at_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en_o |-> level_o == MID);
  assert_audio_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_en_o && !clk_lock_i) |=> !audio_en_o);

endmodule

// File: tb/pwrup_ramp_seq_test.sv
module pwrup_ramp_seq_test;
  localparam int PERIOD = 10;
  localparam int CW     = 6;
  localparam int N      = 3;
  localparam int MID    = 1 << (CW - 1);

  logic clk = 0, rst_n = 0, lock = 0;
  logic clamp, pdown, aen;
  logic [CW-1:0] level;
  logic [1:0] st;
  int checks = 0, errors = 0;
  int m_st = 0, m_lvl = 0, m_cnt = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pwrup_ramp_seq #(.CODE_W(CW), .STEP_DIV(N)) uut (
    .clk(clk), .rst_n(rst_n), .clk_lock_i(lock), .clamp_o(clamp), .pdown_o(pdown),
    .audio_en_o(aen), .level_o(level), .seq_state_o(st)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: ramp states step every N cycles, counted from entry
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_lvl <= 0; m_cnt <= 0;
    end else begin
      bit ramp, tk;
      int ns, nl;
      ramp = (m_st == 1) || (m_st == 3);
      tk   = ramp && (m_cnt == N - 1);
      ns = m_st; nl = m_lvl;
      if (m_st == 1 && tk) nl = m_lvl + 1;
      if (m_st == 3 && tk && m_lvl > 0) nl = m_lvl - 1;
      case (m_st)
        0: ns = lock ? 1 : 0;
        1: ns = !lock ? 3 : (nl == MID ? 2 : 1);
        2: ns = !lock ? 3 : 2;
        default: ns = (nl == 0) ? 0 : 3;
      endcase
      m_cnt <= (!ramp || ns != m_st) ? 0 : (tk ? 0 : m_cnt + 1);
      m_st <= ns; m_lvl <= nl;
    end
  end

  always @(negedge clk) if (!done) begin
    check("R5 state", int'(st), m_st);
    check("R4 level", int'(level), m_lvl);
    check("R9 clamp", int'(clamp), int'(m_st == 0));
    check("R9 pdown", int'(pdown), int'(m_st == 0));
    check("R5 audio_en", int'(aen), int'(m_st == 2));
  end

  task automatic set_lock(input bit v);
    @(negedge clk); #1 lock = v;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 state in reset", int'(st), 0);
    check("R1 clamp in reset", int'(clamp), 1);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 level", int'(level), 0);
    check("R1 audio_en", int'(aen), 0);
    check("R1 pdown", int'(pdown), 1);
    repeat (10) @(negedge clk);
    check("R2 held clamp", int'(clamp), 1);
    check("R2 held level", int'(level), 0);
    // full rise
    set_lock(1);
    @(negedge clk);
    check("R3 entered ramp up", int'(st), 1);
    check("R3 clamp released", int'(clamp), 0);
    repeat (N - 1) @(negedge clk);
    check("R4 no step before N", int'(level), 0);
    @(negedge clk);
    check("R4 first step", int'(level), 1);
    repeat (MID * N - N - 1) @(negedge clk);
    check("R5 still rising", int'(st), 1);
    check("R5 one below mid", int'(level), MID - 1);
    @(negedge clk);
    check("R5 normal", int'(st), 2);
    check("R5 audio on", int'(aen), 1);
    check("R5 level mid", int'(level), MID);
    repeat (5) @(negedge clk);
    // loss in NORMAL
    set_lock(0);
    @(negedge clk);
    check("R6 audio cut", int'(aen), 0);
    check("R6 ramp down", int'(st), 3);
    repeat ((MID / 2) * N) @(negedge clk);
    set_lock(1);
    repeat (4) @(negedge clk);
    check("R8 lock ignored in fall", int'(st), 3);
    while (st != 0) @(negedge clk);
    check("R6 back to ground", int'(level), 0);
    check("R9 clamp in powerdown", int'(clamp), 1);
    @(negedge clk);
    check("R3 relock restarts", int'(st), 1);
    // abort during rise
    repeat (10 * N + 1) @(negedge clk);
    set_lock(0);
    @(negedge clk);
    check("R7 abort to fall", int'(st), 3);
    check("R7 level kept", int'(level != 0), 1);
    while (st != 0) @(negedge clk);
    // one-cycle lock pulse, then abort immediately
    set_lock(1);
    set_lock(0);
    @(negedge clk);
    check("R7 fall from zero", int'(st), 3);
    @(negedge clk);
    check("R7 powerdown again", int'(st), 0);
    repeat (20) @(negedge clk);
    check("R2 stays down", int'(clamp), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule